// File: doc/BRIEF.md
# Asynchronous Serial Port

This block is a full-duplex asynchronous serial port driven through a small register port. A divisor register sets a 16x oversampling tick taken from the system clock. The transmitter sends one bit for every 16 ticks. The receiver samples the line at every tick, qualifies start bits, votes on the middle of each bit and delivers the result to a data register. A data word holds 8 or 9 bits, so a frame is 10 or 11 bits long: start, data with the least significant bit first, and stop.

Software sees five status flags: transmit buffer empty, transmit complete, receive buffer full, line idle and framing error. The flags update all the time and can be polled. Four of them can each be routed to the single interrupt output. The receive-side flags are cleared by a handshake: a status read that observes the flag, followed by a data read. Register map, 2-bit word address:
- 0: baud divisor, bits [12:0]
- 1: control. bit0 receive enable, bit1 transmit enable, bit2 nine-bit mode, bit4 interrupt on empty, bit5 on complete, bit6 on receive full, bit7 on idle
- 2: status. bit0 empty, bit1 complete, bit2 receive full, bit3 idle, bit4 framing error
- 3: data, bits [8:0]

The transmit buffer hands its word to the shift register over an internal valid/ready pair. The buffer holds data (valid) until the shifter is enabled and free (ready). Software exerts the only back-pressure: it must see the empty flag before it writes again, because a write to a full buffer replaces the waiting word.

Top module: `asc_port`

## Requirements
- R1: After reset, txd is 1, irq is 0, and status reads empty=1 and complete=1, with receive full, idle and framing error all 0.
- R2: A divisor N (0 acts as 1) gives one sample tick every N clocks. Each transmitted bit lasts 16 ticks. An 8-bit frame is a 0 start bit, eight data bits LSB first and a 1 stop bit, and it starts the cycle after the buffered word is taken.
- R3: With control bit2 set, frames carry nine data bits (11-bit frame). Data bit 8 is transmitted from data register bit 8, and received bit 8 is read back in bit 8.
- R4: With control bit2 clear, data register bit 8 is ignored on write and reads back 0 for received words.
- R5: A data-register write clears empty and complete. Empty sets again when the word moves into the shift register. Complete sets when a stop bit ends and no word is waiting.
- R6: While transmit enable (control bit1) is 0, txd stays 1 and a written word waits in the buffer with empty=0. Once enabled, the word is sent.
- R7: The receiver decides each bit by majority of samples 7, 8 and 9 of 16. At the middle of the stop bit it loads the data register and sets receive full.
- R8: A 1-to-0 line change starts a frame only if at least three consecutive one samples came just before it. Otherwise it is ignored.
- R9: A stop bit voted as 0 sets the framing error flag together with receive full.
- R10: Idle sets once after a frame length times 16 consecutive one samples. It is armed again only by a zero sample.
- R11: Receive full, idle and framing error clear on a data read only if a status read made while that flag was set came before it. A data read with no such status read leaves them set.
- R12: Control bits 4 to 7 gate empty, complete, receive full and idle onto irq. The flags update whether or not they are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Combined enabled-flag interrupt |

## Verification
A frame leaves txd one cycle after the buffered word is taken, and each bit then lasts 16 times the divisor clocks. The bench decodes txd half a bit after the falling start edge and then once every bit time, so no sample lands near a transition. Receive full and framing error rise about two synchroniser cycles plus one register after sample 9 of the stop bit. That is well before the driver finishes the stop bit, so the bench reads status only after the whole frame has been driven. Idle needs 160 or 176 one samples, so the bench tests it about 200 cycles after the last zero and tests its absence about 10 cycles after the stop bit.

// File: rtl/asc_pkg.sv
package asc_pkg;
  localparam logic [1:0] A_DIV  = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  typedef struct packed {
    logic ie_idle;
    logic ie_rdrf;
    logic ie_tc;
    logic ie_tdre;
    logic spare;
    logic nine;
    logic tx_en;
    logic rx_en;
  } cfg_t;

  typedef enum logic {RX_HUNT, RX_FRAME} rx_state_e;
endpackage

// File: rtl/asc_baud_gen.sv
module asc_baud_gen #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? '0 : div - DIV_W'(1);
  assign tick = (cnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/asc_tx.sv
module asc_tx #(
  parameter int OSR = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          nine,
  input  logic          buf_valid,
  input  logic [DW-1:0] buf_data,
  output logic          buf_ready,
  output logic          txd,
  output logic          busy,
  output logic          done
);
  localparam int FW    = DW + 2;
  localparam int OSR_W = $clog2(OSR);
  localparam int BIT_W = $clog2(FW + 1);

  logic [FW-1:0]    shift_q;
  logic [FW-1:0]    frame_w;
  logic [OSR_W-1:0] phase_q;
  logic [BIT_W-1:0] bit_q;
  logic [BIT_W-1:0] last_bit;
  logic             busy_q;
  logic             take;
  logic             bit_end;

  assign last_bit  = nine ? BIT_W'(DW + 1) : BIT_W'(DW);
  assign buf_ready = en && !busy_q;
  assign take      = buf_valid && buf_ready;
  assign bit_end   = busy_q && tick && (phase_q == OSR_W'(OSR - 1));
  assign done      = en && bit_end && (bit_q == last_bit);
  assign txd       = (en && busy_q) ? shift_q[0] : 1'b1;
  assign busy      = busy_q;

  always_comb begin
    frame_w = {1'b1, buf_data, 1'b0};
    if (!nine) frame_w[DW] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      shift_q <= '1;
      phase_q <= '0;
      bit_q   <= '0;
    end else if (!en) begin
      busy_q  <= 1'b0;
    end else if (take) begin
      busy_q  <= 1'b1;
      shift_q <= frame_w;
      phase_q <= '0;
      bit_q   <= '0;
    end else if (busy_q && tick) begin
      if (bit_end) begin
        phase_q <= '0;
        if (bit_q == last_bit) begin
          busy_q <= 1'b0;
        end else begin
          bit_q   <= bit_q + BIT_W'(1);
          shift_q <= {1'b1, shift_q[FW-1:1]};
        end
      end else begin
        phase_q <= phase_q + OSR_W'(1);
      end
    end
  end
endmodule

// File: rtl/asc_rx.sv
module asc_rx import asc_pkg::*; #(
  parameter int OSR = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          nine,
  input  logic          rxd_raw,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          ferr,
  output logic          idle_pulse
);
  localparam int FW       = DW + 2;
  localparam int OSR_W    = $clog2(OSR);
  localparam int BIT_W    = $clog2(FW + 1);
  localparam int MID      = OSR / 2;
  localparam int IDLE_W   = $clog2(OSR * FW + 1);
  localparam int ONES_REQ = 3;

  logic [1:0]        sync_q;
  logic              rxs;
  logic [1:0]        ones_q;
  rx_state_e         st_q;
  logic [OSR_W-1:0]  phase_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BIT_W-1:0]  last_bit;
  logic [1:0]        vote_q;
  logic              maj;
  logic [DW-1:0]     shift_q;
  logic [IDLE_W-1:0] idle_cnt_q;
  logic [IDLE_W-1:0] idle_lim;
  logic              idle_arm_q;
  logic              decide;

  assign rxs      = sync_q[1];
  assign last_bit = nine ? BIT_W'(DW + 1) : BIT_W'(DW);
  assign idle_lim = nine ? IDLE_W'(OSR * FW) : IDLE_W'(OSR * (FW - 1));
  assign maj      = (vote_q[0] & vote_q[1]) | (vote_q[0] & rxs) | (vote_q[1] & rxs);
  assign decide   = en && tick && (st_q == RX_FRAME) && (phase_q == OSR_W'(MID));
  assign done     = decide && (bit_q == last_bit);
  assign ferr     = !maj;
  assign data     = nine ? shift_q : (shift_q >> 1);
  assign idle_pulse = en && tick && rxs && idle_arm_q && (idle_cnt_q == idle_lim - IDLE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      ones_q <= '0;
    end else begin
      sync_q <= {sync_q[0], rxd_raw};
      if (tick) begin
        if (!rxs)                          ones_q <= '0;
        else if (ones_q != 2'(ONES_REQ))  ones_q <= ones_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt_q <= '0;
      idle_arm_q <= 1'b1;
    end else if (en && tick) begin
      if (!rxs) begin
        idle_cnt_q <= '0;
        idle_arm_q <= 1'b1;
      end else if (idle_arm_q) begin
        if (idle_pulse) begin
          idle_cnt_q <= '0;
          idle_arm_q <= 1'b0;
        end else begin
          idle_cnt_q <= idle_cnt_q + IDLE_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_HUNT;
      phase_q <= '0;
      bit_q   <= '0;
      vote_q  <= '0;
      shift_q <= '0;
    end else if (!en) begin
      st_q    <= RX_HUNT;
    end else if (tick) begin
      if (st_q == RX_HUNT) begin
        if (!rxs && ones_q == 2'(ONES_REQ)) begin
          st_q    <= RX_FRAME;
          phase_q <= OSR_W'(1);
          bit_q   <= '0;
        end
      end else begin
        phase_q <= phase_q + OSR_W'(1);
        if (phase_q == OSR_W'(OSR - 1)) begin
          phase_q <= '0;
          bit_q   <= bit_q + BIT_W'(1);
        end
        if (phase_q == OSR_W'(MID - 2)) vote_q[0] <= rxs;
        if (phase_q == OSR_W'(MID - 1)) vote_q[1] <= rxs;
        if (decide) begin
          if (bit_q == '0) begin
            if (maj) st_q <= RX_HUNT;
          end else if (bit_q == last_bit) begin
            st_q <= RX_HUNT;
          end else begin
            shift_q <= {maj, shift_q[DW-1:1]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/asc_port.sv
module asc_port import asc_pkg::*; #(
  parameter int DIV_W   = 13,
  parameter int OSR     = 16,
  parameter int DW      = 9,
  parameter int DIV_RST = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        rxd,
  output logic        txd,
  output logic        irq
);
  cfg_t             cfg_q;
  logic [DIV_W-1:0] div_q;
  logic [DW-1:0]    tdr_q;
  logic [DW-1:0]    rdr_q;
  logic             tdr_full_q;
  logic             tc_q;
  logic             rdrf_q;
  logic             idle_q;
  logic             ferr_q;
  logic [2:0]       arm_q;
  logic             wr_div, wr_ctrl, wr_data, rd_stat, rd_data;
  logic             tick;
  logic             buf_ready, tx_done, tx_busy_w;
  logic             rx_done_w, rx_ferr, rx_idle_w;
  logic [DW-1:0]    rx_data;
  logic             tdre_w, tx_en_w;
  logic [4:0]       stat_w;
  logic             unused_hi;

  assign unused_hi = ^bus_wdata[15:DIV_W];
  assign wr_div  = bus_sel && bus_wr  && bus_addr == A_DIV;
  assign wr_ctrl = bus_sel && bus_wr  && bus_addr == A_CTRL;
  assign wr_data = bus_sel && bus_wr  && bus_addr == A_DATA;
  assign rd_stat = bus_sel && !bus_wr && bus_addr == A_STAT;
  assign rd_data = bus_sel && !bus_wr && bus_addr == A_DATA;
  assign tdre_w  = !tdr_full_q;
  assign tx_en_w = cfg_q.tx_en;
  assign stat_w  = {ferr_q, idle_q, rdrf_q, tc_q, tdre_w};
  assign irq     = |({idle_q, rdrf_q, tc_q, tdre_w} &
                     {cfg_q.ie_idle, cfg_q.ie_rdrf, cfg_q.ie_tc, cfg_q.ie_tdre});

  asc_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
  );

  asc_tx #(.OSR(OSR), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(cfg_q.tx_en), .nine(cfg_q.nine),
    .buf_valid(tdr_full_q), .buf_data(tdr_q), .buf_ready(buf_ready),
    .txd(txd), .busy(tx_busy_w), .done(tx_done)
  );

  asc_rx #(.OSR(OSR), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(cfg_q.rx_en), .nine(cfg_q.nine),
    .rxd_raw(rxd), .done(rx_done_w), .data(rx_data), .ferr(rx_ferr),
    .idle_pulse(rx_idle_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      div_q      <= DIV_W'(DIV_RST);
      tdr_q      <= '0;
      rdr_q      <= '0;
      tdr_full_q <= 1'b0;
      tc_q       <= 1'b1;
      rdrf_q     <= 1'b0;
      idle_q     <= 1'b0;
      ferr_q     <= 1'b0;
      arm_q      <= '0;
    end else begin
      if (wr_div)  div_q <= bus_wdata[DIV_W-1:0];
      if (wr_ctrl) cfg_q <= cfg_t'(bus_wdata[7:0] & 8'hF7);
      if (tdr_full_q && buf_ready) tdr_full_q <= 1'b0;
      if (tx_done && !tdr_full_q)  tc_q <= 1'b1;
      if (wr_data) begin
        tdr_q      <= cfg_q.nine ? bus_wdata[DW-1:0] : {1'b0, bus_wdata[DW-2:0]};
        tdr_full_q <= 1'b1;
        tc_q       <= 1'b0;
      end
      if (rd_stat) arm_q <= {ferr_q, idle_q, rdrf_q};
      if (rd_data) begin
        if (arm_q[0]) rdrf_q <= 1'b0;
        if (arm_q[1]) idle_q <= 1'b0;
        if (arm_q[2]) ferr_q <= 1'b0;
        arm_q <= '0;
      end
      if (rx_done_w) begin
        rdr_q  <= rx_data;
        rdrf_q <= 1'b1;
        ferr_q <= rx_ferr;
      end
      if (rx_idle_w) idle_q <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_DIV:   bus_rdata = 16'(div_q);
      A_CTRL:  bus_rdata = {8'h00, cfg_q};
      A_STAT:  bus_rdata = {11'h000, stat_w};
      default: bus_rdata = 16'(rdr_q);
    endcase
  end
endmodule

// File: rtl/asc_port_chk.sv
module asc_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       txd,
  input logic       tx_en,
  input logic       tx_busy,
  input logic       tdre,
  input logic       tc,
  input logic       rdrf,
  input logic       idle,
  input logic       rx_done,
  input logic       rx_idle
);
  logic data_wr, data_rd;
  assign data_wr = bus_sel && bus_wr  && bus_addr == 2'd3;
  assign data_rd = bus_sel && !bus_wr && bus_addr == 2'd3;

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);
  // R5
  tdre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !tdre);
  // R5
  tc_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tc) |-> $past(data_wr));
  // R6
  txd_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> txd);
  // R7
  rdrf_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdrf) |-> $past(rx_done));
  // R10
  idle_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> $past(rx_idle));
  // R11
  rdrf_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdrf) |-> $past(data_rd));
endmodule

bind asc_port asc_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .txd(txd), .tx_en(tx_en_w), .tx_busy(tx_busy_w),
  .tdre(tdre_w), .tc(tc_q), .rdrf(rdrf_q), .idle(idle_q),
  .rx_done(rx_done_w), .rx_idle(rx_idle_w)
);

// File: tb/test_asc_port.sv
`timescale 1ns/1ps
module test_asc_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        rxd = 1'b1;
  logic        txd;
  logic        irq;

  typedef struct { logic [8:0] d; int n; } frame_t;
  frame_t tx_q[$];
  int vectors = 0;
  int fails = 0;
  int bit_period = 16;

  always #2 clk = ~clk;

  asc_port i_asc_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd), .irq(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // driver: expected frame into the scoreboard, then the write
  task automatic tx_push(logic [15:0] w, logic [8:0] exp, int n);
    frame_t f;
    f.d = exp; f.n = n;
    tx_q.push_back(f);
    bus_write(2'd3, w);
  endtask

  task automatic wait_tc();
    logic [15:0] s;
    for (int i = 0; i < 3000; i++) begin
      bus_read(2'd2, s);
      if (s[1]) break;
    end
    chk("R5 complete after last frame", 16'(s[1]), 16'd1);
  endtask

  task automatic rx_send(logic [8:0] d, int n, logic stopv);
    @(negedge clk);
    rxd = 1'b0;
    repeat (bit_period) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = d[i];
      repeat (bit_period) @(negedge clk);
    end
    rxd = stopv;
    repeat (bit_period) @(negedge clk);
    rxd = 1'b1;
  endtask

  // monitor: decodes txd and compares against the scoreboard
  initial begin
    logic prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !txd) begin
        frame_t f;
        logic [8:0] got = '0;
        string req;
        repeat (bit_period / 2 - 1) @(negedge clk);
        if (tx_q.size() == 0) begin
          f.d = '0; f.n = 8;
          fails++; vectors++;
          $display("FAIL R2 unexpected frame actual=1 expected=0");
        end else f = tx_q.pop_front();
        req = (f.n == 9) ? "R3 nine-bit frame" : "R2 frame";
        chk({req, " start"}, 16'(txd), 16'd0);
        for (int i = 0; i < f.n; i++) begin
          repeat (bit_period) @(negedge clk);
          got[i] = txd;
        end
        repeat (bit_period) @(negedge clk);
        chk({req, " stop"}, 16'(txd), 16'd1);
        chk({req, " data"}, 16'(got), 16'(f.d));
      end
      prev = txd;
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [15:0] s, d;
    int bad;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd", 16'(txd), 16'd1);
    chk("R1 irq", 16'(irq), 16'd0);
    bus_read(2'd2, s);
    chk("R1 status", s, 16'h0003);

    // R12 interrupt gating
    bus_write(2'd1, 16'h0010);
    chk("R12 irq from empty", 16'(irq), 16'd1);
    bus_write(2'd1, 16'h0020);
    chk("R12 irq from complete", 16'(irq), 16'd1);
    bus_write(2'd1, 16'h00C0);
    chk("R12 irq masked flags clear", 16'(irq), 16'd0);
    bus_write(2'd1, 16'h0000);
    chk("R12 irq all disabled", 16'(irq), 16'd0);

    // R6 transmitter disabled
    bus_write(2'd1, 16'h0001);
    tx_push(16'h0033, 9'h033, 8);
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) bad++;
    end
    chk("R6 txd held high", 16'(bad), 16'd0);
    bus_read(2'd2, s);
    chk("R6 word waits", 16'(s[0]), 16'd0);
    bus_write(2'd1, 16'h0003);
    wait_tc();

    // R5 back-to-back words
    tx_push(16'h00A5, 9'h0A5, 8);
    repeat (4) @(negedge clk);
    tx_push(16'h005C, 9'h05C, 8);
    bus_read(2'd2, s);
    chk("R5 empty clear while waiting", 16'(s[1:0]), 16'd0);
    repeat (170) @(negedge clk);
    bus_read(2'd2, s);
    chk("R5 empty set after hand-off", 16'(s[1:0]), 16'd1);
    wait_tc();

    // R3 nine-bit transmit
    bus_write(2'd1, 16'h0007);
    tx_push(16'h013C, 9'h13C, 9);
    wait_tc();
    tx_push(16'h00C1, 9'h0C1, 9);
    wait_tc();
    // R4 bit 8 ignored in 8-bit mode
    bus_write(2'd1, 16'h0003);
    tx_push(16'h01AA, 9'h0AA, 8);
    wait_tc();

    // receive: flush flags first
    bus_read(2'd2, s);
    bus_read(2'd3, d);
    // R7 8-bit receive
    rx_send(9'h05A, 8, 1'b1);
    bus_read(2'd2, s);
    chk("R7 receive full", 16'(s[2]), 16'd1);
    chk("R10 idle clear after frame", 16'(s[3]), 16'd0);
    chk("R9 no framing error", 16'(s[4]), 16'd0);
    bus_read(2'd3, d);
    chk("R7 data", d, 16'h005A);
    bus_read(2'd2, s);
    chk("R11 cleared by sequence", 16'(s[2]), 16'd0);
    // R10 idle
    repeat (200) @(negedge clk);
    bus_read(2'd2, s);
    chk("R10 idle set", 16'(s[3]), 16'd1);
    bus_read(2'd3, d);
    repeat (200) @(negedge clk);
    bus_read(2'd2, s);
    chk("R10 idle once only", 16'(s[3]), 16'd0);

    // R11 data read without status read; R12 receive interrupt
    bus_write(2'd1, 16'h0043);
    rx_send(9'h03C, 8, 1'b1);
    chk("R12 irq receive full", 16'(irq), 16'd1);
    bus_read(2'd3, d);
    chk("R4 receive bit8 zero", d, 16'h003C);
    bus_read(2'd2, s);
    chk("R11 not cleared unarmed", 16'(s[2]), 16'd1);
    bus_read(2'd3, d);
    chk("R12 irq drops", 16'(irq), 16'd0);
    bus_read(2'd2, s);
    chk("R11 cleared after status read", 16'(s[2]), 16'd0);

    // R3 nine-bit receive
    bus_write(2'd1, 16'h0007);
    rx_send(9'h1C3, 9, 1'b1);
    bus_read(2'd2, s);
    bus_read(2'd3, d);
    chk("R3 nine-bit receive", d, 16'h01C3);
    bus_write(2'd1, 16'h0003);

    // R9 break gives framing error
    repeat (40) @(negedge clk);
    rxd = 1'b0;
    repeat (250) @(negedge clk);
    bus_read(2'd2, s);
    chk("R9 framing error with full", 16'(s[4:2] & 3'b101), 16'h0005);
    bus_read(2'd3, d);
    chk("R9 break data", d, 16'h0000);
    bus_read(2'd2, s);
    chk("R9 error cleared", 16'(s[4:2] & 3'b101), 16'h0000);
    // R8 only two one samples before the fall
    rxd = 1'b1;
    repeat (2) @(negedge clk);
    rxd = 1'b0;
    repeat (250) @(negedge clk);
    rxd = 1'b1;
    repeat (30) @(negedge clk);
    bus_read(2'd2, s);
    chk("R8 unqualified start ignored", 16'(s[2]), 16'd0);
    repeat (40) @(negedge clk);
    rx_send(9'h096, 8, 1'b1);
    bus_read(2'd2, s);
    bus_read(2'd3, d);
    chk("R8 qualified start accepted", d, 16'h0096);

    // R2 divisor 2
    bus_write(2'd0, 16'h0002);
    bit_period = 32;
    tx_push(16'h003C, 9'h03C, 8);
    wait_tc();
    chk("R2 all frames seen", 16'(tx_q.size()), 16'd0);
    summary();
  end
endmodule